// File: doc/BRIEF.md
# Token-Passing Column Readout Controller

This block gathers pixel hits column by column and drains them in a round-robin token sweep. Hits arrive on the crossing-side clock. Each one carries a column, a row and a 3-bit amplitude. It is stored in the command set of that column that is currently listening. Each column has a small pool of command sets. A set collects hits during one crossing and takes the crossing number as its time stamp when the crossing closes. A crossing is closed by a one-cycle `xadv` pulse. The set's ready flag is raised one crossing later.

The ready flags pass to the readout clock through two-flop synchronizers. A token then visits every column that holds a ready set, from the lowest column upward. At each visit it drains one set, one 24-bit word per readout clock. Sync/status words mark the boundaries of each sweep. A release flag goes back through a second pair of synchronizers, so that the drained set can be used again.

Each command set moves through four states:
- `SET_FREE` to `SET_LISTEN`: the column has no listening set.
- `SET_LISTEN` to `SET_IDLE`: on `xadv` if the set holds at least one hit.
- `SET_IDLE` to `SET_OUTPUT`: on the next `xadv`.
- `SET_OUTPUT` to `SET_FREE`: once the synchronized release flag matches its ready flag.

The token machine also has four states:
- `TK_IDLE` to `TK_DRAIN`: when any set is pending.
- `TK_DRAIN` to `TK_DRAIN`: the next hit, or the next higher pending column.
- `TK_DRAIN` to `TK_SWEEP_END`: after the last hit, when no higher column is pending.
- `TK_SWEEP_END` to `TK_RELAUNCH` if data is still pending, otherwise back to `TK_IDLE`.
- `TK_RELAUNCH` to `TK_DRAIN`.

Top module: `trk_readout`

## Requirements
- R1: While reset is low, and after it is released with no hits, `out_sync` is 1, `out_word` is the sync word 24'h000001, and `drop_cnt` is 0.
- R2: A hit is tagged with the crossing number of the crossing during which it arrived. The crossing number counts the `xadv` pulses since reset, modulo 256. A hit presented in the same cycle as `xadv` belongs to the crossing that this pulse closes.
- R3: `xadv` closes a non-empty listening set, and the following `xadv` makes it ready. A listening set that holds no hits stays listening, so crossings without hits produce no data words.
- R4: Once a set becomes ready, the first data word appears within four readout cycles. Idle sync words precede it.
- R5: A data word has this layout:
  - bits 23:17: the row
  - bits 16:12: the column index plus 1
  - bits 11:4: the stamp
  - bits 3:1: the amplitude
  - bit 0: always 1

  Data words drive `out_sync` low.
- R6: The hits of one set leave on consecutive readout cycles in their order of arrival before the token moves on.
- R7: Within a sweep the token visits pending columns in ascending order and drains exactly one set per visit. A set that becomes ready in a column the token has already passed waits for the next sweep.
- R8: After the last data word of a sweep, exactly one sync word follows when nothing is pending, and the stream then stays at sync words.
- R9: When data is still pending at the end of a sweep, exactly two sync words separate the sweeps. The next sweep starts at the lowest pending column.
- R10: Each column holds 2 sets of 4 hits each. A hit to a full listening set, to a column with no listening set, or to a column index of 22 or more is discarded, and `drop_cnt` rises by one.
- R11: A set is freed only after it has been drained and the release has crossed back. Freed sets are reused, so repeated single-crossing bursts of up to 4 hits per column cause no drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xclk | input | 1 | Crossing-side clock |
| rclk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| xadv | input | 1 | Crossing advance pulse (xclk domain) |
| hit_vld | input | 1 | Hit strobe (xclk domain) |
| hit_col | input | 5 | Column of the hit |
| hit_row | input | 7 | Row of the hit |
| hit_adc | input | 3 | Amplitude of the hit |
| out_word | output | 24 | Output word, one per readout clock |
| out_sync | output | 1 | 1 when `out_word` is a sync/status word |
| drop_cnt | output | 16 | Count of discarded hits (xclk domain) |

## Verification
The hardest case to reach from the ports is a set that becomes ready in a column the token has just passed. That set must wait for a second sweep, which is preceded by the double sync word. The stimulus first loads all 22 columns with four hits each, so that the first sweep lasts 88 readout cycles. Two low columns receive hits in the next crossing. Their ready edge is placed about thirty crossing-clock cycles into the long sweep, after the token has moved past them. Patterned bursts whose per-column hit count is computed arithmetically exercise ascending order, set reuse and the word layout across the full column range.

// File: rtl/trk_pkg.sv
package trk_pkg;

    localparam int ROW_W   = 7;
    localparam int ADC_W   = 3;
    localparam int STAMP_W = 8;
    localparam int CCODE_W = 5;
    localparam int WORD_W  = 24;

    localparam logic [WORD_W-1:0] SYNC_WORD = 24'h000001;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [ADC_W-1:0] adc;
    } hit_t;

    typedef enum logic [1:0] {
        SET_FREE,
        SET_LISTEN,
        SET_IDLE,
        SET_OUTPUT
    } set_st_e;

    typedef enum logic [1:0] {
        TK_IDLE,
        TK_DRAIN,
        TK_SWEEP_END,
        TK_RELAUNCH
    } tok_st_e;

    function automatic logic [WORD_W-1:0] pack_word(hit_t h, logic [CCODE_W-1:0] cc,
                                                    logic [STAMP_W-1:0] ts);
        return {h.row, cc, ts, h.adc, 1'b1};
    endfunction

endpackage

// File: rtl/trk_sync2.sv
module trk_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/trk_column.sv
module trk_column
    import trk_pkg::*;
#(
    parameter int SETS  = 2,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         xadv,
    input  logic [STAMP_W-1:0]           xnum,
    input  logic                         hit_vld,
    input  hit_t                         hit_in,
    input  logic [SETS-1:0]              done_in,
    output logic [SETS-1:0]              rdy_out,
    input  logic [$clog2(SETS)-1:0]      rd_set,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output hit_t                         rd_hit,
    output logic [STAMP_W-1:0]           rd_stamp,
    output logic [$clog2(DEPTH+1)-1:0]   rd_cnt,
    output logic                         drop
);

    localparam int SET_W = $clog2(SETS);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    set_st_e            st      [SETS];
    logic [CNT_W-1:0]   cnt     [SETS];
    logic [STAMP_W-1:0] stamp_q [SETS];
    hit_t               mem     [SETS][DEPTH];
    logic [SETS-1:0]    rdy_q;
    logic [SETS-1:0]    listen_mask;

    logic               has_listen, has_free, accept, closing, promote;
    logic [SET_W-1:0]   lsn, fre;

    // Find the listening set and the lowest free set
    always_comb begin
        has_listen  = 1'b0;
        has_free    = 1'b0;
        lsn         = '0;
        fre         = '0;
        listen_mask = '0;
        for (int s = SETS - 1; s >= 0; s--) begin
            if (st[s] == SET_LISTEN) begin
                has_listen     = 1'b1;
                lsn            = SET_W'(s);
                listen_mask[s] = 1'b1;
            end
            if (st[s] == SET_FREE) begin
                has_free = 1'b1;
                fre      = SET_W'(s);
            end
        end
        accept  = hit_vld && has_listen && (cnt[lsn] < CNT_W'(DEPTH));
        closing = xadv && has_listen && ((cnt[lsn] != '0) || accept);
        promote = has_free && (!has_listen || closing);
        drop    = hit_vld && !accept;
    end

    // Per-set state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                st[s]      <= (s == 0) ? SET_LISTEN : SET_FREE;
                cnt[s]     <= '0;
                stamp_q[s] <= '0;
            end
            rdy_q <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                unique case (st[s])
                    SET_FREE: begin
                        if (promote && (fre == SET_W'(s))) st[s] <= SET_LISTEN;
                    end
                    SET_LISTEN: begin
                        if (accept && (lsn == SET_W'(s))) cnt[s] <= cnt[s] + 1'b1;
                        if (closing && (lsn == SET_W'(s))) begin
                            st[s]      <= SET_IDLE;
                            stamp_q[s] <= xnum;
                        end
                    end
                    SET_IDLE: begin
                        if (xadv) begin
                            st[s]    <= SET_OUTPUT;
                            rdy_q[s] <= ~rdy_q[s];
                        end
                    end
                    SET_OUTPUT: begin
                        if (done_in[s] == rdy_q[s]) begin
                            st[s]  <= SET_FREE;
                            cnt[s] <= '0;
                        end
                    end
                    default: st[s] <= SET_FREE;
                endcase
            end
        end
    end

    // Hit storage, frozen once the set leaves listen
    always_ff @(posedge clk) begin
        if (accept) mem[lsn][cnt[lsn][IDX_W-1:0]] <= hit_in;
    end

    // Read side (set is stable while it is pending in the readout domain)
    always_comb begin
        rdy_out  = rdy_q;
        rd_hit   = mem[rd_set][rd_idx];
        rd_stamp = stamp_q[rd_set];
        rd_cnt   = cnt[rd_set];
    end

    AST_ONE_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(listen_mask) <= 1); // R10

    for (genvar g = 0; g < SETS; g++) begin : g_set_chk
        AST_IDLE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == SET_IDLE && xadv) |=> (st[g] == SET_OUTPUT)); // R3
        AST_OUTPUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == SET_OUTPUT) |=> (st[g] == SET_FREE || $stable(cnt[g]))); // R6
    end

endmodule

// File: rtl/trk_token.sv
module trk_token
    import trk_pkg::*;
#(
    parameter int NCOL  = 22,
    parameter int SETS  = 2,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCOL*SETS-1:0]         rdy_in,
    output logic [NCOL*SETS-1:0]         done_out,
    output logic [$clog2(NCOL)-1:0]      cur_col,
    output logic [$clog2(SETS)-1:0]      cur_set,
    output logic [$clog2(DEPTH)-1:0]     cur_idx,
    input  logic [$clog2(DEPTH+1)-1:0]   rd_cnt,
    input  hit_t                         rd_hit,
    input  logic [STAMP_W-1:0]           rd_stamp,
    output logic [WORD_W-1:0]            out_word,
    output logic                         out_sync
);

    localparam int CIX_W = $clog2(NCOL);
    localparam int SET_W = $clog2(SETS);
    localparam int IDX_W = $clog2(DEPTH);

    tok_st_e             st_q, st_d;
    logic [CIX_W-1:0]    col_q, col_d;
    logic [SET_W-1:0]    set_q, set_d;
    logic [IDX_W-1:0]    idx_q, idx_d;
    logic [NCOL*SETS-1:0] done_q, pending;
    logic [NCOL-1:0]     pend_col;
    logic                done_flip, last_hit;
    logic                first_any, next_any;
    logic [CIX_W-1:0]    first_col, next_col;
    logic [SET_W-1:0]    first_set, next_set;

    assign pending = rdy_in ^ done_q;

    for (genvar c = 0; c < NCOL; c++) begin : g_pend
        assign pend_col[c] = |pending[c*SETS +: SETS];
    end

    // Lowest pending column overall and above the token
    always_comb begin
        first_any = 1'b0;
        next_any  = 1'b0;
        first_col = '0;
        next_col  = '0;
        first_set = '0;
        next_set  = '0;
        for (int c = NCOL - 1; c >= 0; c--) begin
            if (pend_col[c]) begin
                first_any = 1'b1;
                first_col = CIX_W'(c);
            end
            if (pend_col[c] && (CIX_W'(c) > col_q)) begin
                next_any = 1'b1;
                next_col = CIX_W'(c);
            end
        end
        for (int s = SETS - 1; s >= 0; s--) begin
            if (pending[int'(first_col)*SETS + s]) first_set = SET_W'(s);
            if (pending[int'(next_col)*SETS + s])  next_set  = SET_W'(s);
        end
        last_hit = (idx_q == IDX_W'(rd_cnt - 1'b1));
    end

    // Next-state logic
    always_comb begin
        st_d      = st_q;
        col_d     = col_q;
        set_d     = set_q;
        idx_d     = idx_q;
        done_flip = 1'b0;
        unique case (st_q)
            TK_IDLE: begin
                if (first_any) begin
                    st_d  = TK_DRAIN;
                    col_d = first_col;
                    set_d = first_set;
                    idx_d = '0;
                end
            end
            TK_DRAIN: begin
                if (last_hit) begin
                    done_flip = 1'b1;
                    if (next_any) begin
                        col_d = next_col;
                        set_d = next_set;
                        idx_d = '0;
                    end else begin
                        st_d = TK_SWEEP_END;
                    end
                end else begin
                    idx_d = IDX_W'(idx_q + 1'b1);
                end
            end
            TK_SWEEP_END: begin
                st_d = first_any ? TK_RELAUNCH : TK_IDLE;
            end
            TK_RELAUNCH: begin
                st_d  = TK_DRAIN;
                col_d = first_col;
                set_d = first_set;
                idx_d = '0;
            end
            default: st_d = TK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TK_IDLE;
            col_q  <= '0;
            set_q  <= '0;
            idx_q  <= '0;
            done_q <= '0;
        end else begin
            st_q  <= st_d;
            col_q <= col_d;
            set_q <= set_d;
            idx_q <= idx_d;
            if (done_flip) done_q[int'(col_q)*SETS + int'(set_q)] <= ~done_q[int'(col_q)*SETS + int'(set_q)];
        end
    end

    // Outputs
    always_comb begin
        out_sync = (st_q != TK_DRAIN);
        out_word = out_sync ? SYNC_WORD
                            : pack_word(rd_hit, CCODE_W'(col_q) + CCODE_W'(1), rd_stamp);
        done_out = done_q;
        cur_col  = col_q;
        cur_set  = set_q;
        cur_idx  = idx_q;
    end

    AST_DRAIN_OWNS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TK_DRAIN) |-> pending[int'(col_q)*SETS + int'(set_q)]); // R6
    AST_DATA_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_sync) |-> ($past(st_q) == TK_IDLE || $past(st_q) == TK_RELAUNCH)); // R9
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TK_DRAIN && $past(st_q) == TK_DRAIN && col_q != $past(col_q))
            |-> (col_q > $past(col_q))); // R7

endmodule

// File: rtl/trk_readout.sv
module trk_readout
    import trk_pkg::*;
#(
    parameter int NCOL  = 22,
    parameter int SETS  = 2,
    parameter int DEPTH = 4
) (
    input  logic        xclk,
    input  logic        rclk,
    input  logic        rst_n,
    input  logic        xadv,
    input  logic        hit_vld,
    input  logic [4:0]  hit_col,
    input  logic [6:0]  hit_row,
    input  logic [2:0]  hit_adc,
    output logic [23:0] out_word,
    output logic        out_sync,
    output logic [15:0] drop_cnt
);

    localparam int CIX_W = $clog2(NCOL);
    localparam int SET_W = $clog2(SETS);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NFLAG = NCOL * SETS;

    logic [STAMP_W-1:0] xnum;
    hit_t               hit_in;
    hit_t               col_hit   [NCOL];
    logic [STAMP_W-1:0] col_stamp [NCOL];
    logic [CNT_W-1:0]   col_cnt   [NCOL];
    logic [NCOL-1:0]    col_drop;
    logic [NFLAG-1:0]   rdy_x, rdy_r, done_r, done_x;
    logic [CIX_W-1:0]   cur_col;
    logic [SET_W-1:0]   cur_set;
    logic [IDX_W-1:0]   cur_idx;
    logic               bad_col;

    assign hit_in  = '{row: hit_row, adc: hit_adc};
    assign bad_col = hit_vld && (hit_col >= 5'(NCOL));

    // Crossing number
    always_ff @(posedge xclk or negedge rst_n) begin
        if (!rst_n)    xnum <= '0;
        else if (xadv) xnum <= xnum + 1'b1;
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        trk_column #(.SETS(SETS), .DEPTH(DEPTH)) u_col (
            .clk      (xclk),
            .rst_n    (rst_n),
            .xadv     (xadv),
            .xnum     (xnum),
            .hit_vld  (hit_vld && (hit_col == 5'(c))),
            .hit_in   (hit_in),
            .done_in  (done_x[c*SETS +: SETS]),
            .rdy_out  (rdy_x[c*SETS +: SETS]),
            .rd_set   (cur_set),
            .rd_idx   (cur_idx),
            .rd_hit   (col_hit[c]),
            .rd_stamp (col_stamp[c]),
            .rd_cnt   (col_cnt[c]),
            .drop     (col_drop[c])
        );
    end

    trk_sync2 #(.W(NFLAG)) u_rdy_sync (
        .clk(rclk), .rst_n(rst_n), .d(rdy_x), .q(rdy_r)
    );

    trk_sync2 #(.W(NFLAG)) u_done_sync (
        .clk(xclk), .rst_n(rst_n), .d(done_r), .q(done_x)
    );

    trk_token #(.NCOL(NCOL), .SETS(SETS), .DEPTH(DEPTH)) u_token (
        .clk      (rclk),
        .rst_n    (rst_n),
        .rdy_in   (rdy_r),
        .done_out (done_r),
        .cur_col  (cur_col),
        .cur_set  (cur_set),
        .cur_idx  (cur_idx),
        .rd_cnt   (col_cnt[cur_col]),
        .rd_hit   (col_hit[cur_col]),
        .rd_stamp (col_stamp[cur_col]),
        .out_word (out_word),
        .out_sync (out_sync)
    );

    // Discarded-hit counter
    always_ff @(posedge xclk or negedge rst_n) begin
        if (!rst_n)                    drop_cnt <= '0;
        else if (|col_drop || bad_col) drop_cnt <= drop_cnt + 1'b1;
    end

    AST_DROP_STEP: assert property (@(posedge xclk) disable iff (!rst_n)
        (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 16'd1)); // R10
    AST_DROP_ONLY_ON_HIT: assert property (@(posedge xclk) disable iff (!rst_n)
        !hit_vld |=> (drop_cnt == $past(drop_cnt))); // R10

endmodule

// File: tb/trk_readout_tb.sv
module trk_readout_tb;

    localparam int NCOL  = 22;
    localparam int DEPTH = 4;

    logic        xclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic        xadv = 1'b0, hit_vld = 1'b0;
    logic [4:0]  hit_col = '0;
    logic [6:0]  hit_row = '0;
    logic [2:0]  hit_adc = '0;
    logic [23:0] out_word;
    logic        out_sync;
    logic [15:0] drop_cnt;

    trk_readout u_dut (
        .xclk(xclk), .rclk(rclk), .rst_n(rst_n), .xadv(xadv),
        .hit_vld(hit_vld), .hit_col(hit_col), .hit_row(hit_row), .hit_adc(hit_adc),
        .out_word(out_word), .out_sync(out_sync), .drop_cnt(drop_cnt)
    );

    always #4 rclk = ~rclk;   // 125 MHz readout clock
    always #5 xclk = ~xclk;

    int          n_chk = 0, n_fail = 0, xn = 0, mark = 0;
    bit          cap_on = 1'b0, finished = 1'b0;
    logic [24:0] cap[$];
    logic [23:0] exp_a[$], exp_b[$];

    always @(negedge rclk) if (cap_on) cap.push_back({out_sync, out_word});

    task automatic chk(input bit ok, input string msg, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, expv);
        end
    endtask

    function automatic logic [23:0] mkw(int row, int col, int stp, int adc);
        return {7'(row), 5'(col + 1), 8'(stp), 3'(adc), 1'b1};
    endfunction

    function automatic logic [24:0] get(int i);
        return (i < cap.size()) ? cap[i] : 25'h1ffffff;
    endfunction

    task automatic hit(input int c, input int r, input int a);
        @(negedge xclk);
        hit_vld = 1'b1; hit_col = 5'(c); hit_row = 7'(r); hit_adc = 3'(a);
        @(negedge xclk);
        hit_vld = 1'b0;
    endtask

    task automatic advance();
        @(negedge xclk);
        xadv = 1'b1;
        @(negedge xclk);
        xadv = 1'b0;
        xn++;
    endtask

    task automatic hit_adv(input int c, input int r, input int a);
        @(negedge xclk);
        hit_vld = 1'b1; hit_col = 5'(c); hit_row = 7'(r); hit_adc = 3'(a); xadv = 1'b1;
        @(negedge xclk);
        hit_vld = 1'b0; xadv = 1'b0;
        xn++;
    endtask

    function automatic int first_data();
        int i = 0;
        while (i < cap.size() && cap[i][24]) i++;
        return i;
    endfunction

    task automatic check_stream(input string tag);
        int i = first_data();
        int extra = 0;
        if (exp_a.size() == 0) begin
            chk(i == cap.size(), {tag, " R3 no data expected"}, i, cap.size());
        end else begin
            chk(i > 0, {tag, " R4 idle sync before data"}, i, 1);
            foreach (exp_a[j])
                chk(get(i + j) == {1'b0, exp_a[j]}, {tag, " R5 R6 R7 data word"},
                    get(i + j), {1'b0, exp_a[j]});
            i += exp_a.size();
            if (exp_b.size() > 0) begin
                chk(get(i)[24] && get(i + 1)[24] && !get(i + 2)[24], {tag, " R9 two syncs between sweeps"},
                    {get(i)[24], get(i + 1)[24], get(i + 2)[24]}, 3'b110);
                i += 2;
                foreach (exp_b[j])
                    chk(get(i + j) == {1'b0, exp_b[j]}, {tag, " R9 second sweep word"},
                        get(i + j), {1'b0, exp_b[j]});
                i += exp_b.size();
            end
            chk(i < cap.size() && get(i)[24], {tag, " R8 sync after sweep"}, get(i), {1'b1, 24'h000001});
            for (int k = i; k < cap.size(); k++) if (!cap[k][24]) extra++;
            chk(extra == 0, {tag, " R8 no stray data"}, extra, 0);
        end
        cap.delete();
        exp_a.delete();
        exp_b.delete();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (3) @(negedge rclk);
        // R1 during reset
        chk(out_sync == 1'b1, "R1 sync flag in reset", out_sync, 1);
        chk(out_word == 24'h000001, "R1 sync word in reset", out_word, 24'h000001);
        repeat (2) @(negedge xclk);
        rst_n = 1'b1;
        repeat (4) @(negedge rclk);
        chk(out_sync == 1'b1 && out_word == 24'h000001, "R1 idle after reset", out_word, 24'h000001);
        chk(drop_cnt == 16'd0, "R1 drop count", drop_cnt, 0);
        cap_on = 1'b1;

        // R3: crossings without hits
        advance(); advance(); advance();
        repeat (40) @(negedge rclk);
        check_stream("empty");

        // Patterned bursts over all columns (R2 R5 R6 R7 R8 R11)
        for (int k = 1; k <= 3; k++) begin
            for (int c = 0; c < NCOL; c++) begin
                for (int h = 0; h < (c * k + k) % 5; h++) begin
                    hit(c, (c * 3 + h * 7 + k) & 127, (c + h + k) & 7);
                    exp_a.push_back(mkw((c * 3 + h * 7 + k) & 127, c, xn, (c + h + k) & 7));
                end
            end
            advance();
            advance();
            mark = cap.size();
            repeat (200) @(negedge rclk);
            chk(first_data() - mark >= 1 && first_data() - mark <= 4, "R4 launch latency",
                first_data() - mark, 3);
            check_stream("pattern");
        end
        chk(drop_cnt == 16'd0, "R11 set reuse without drops", drop_cnt, 0);

        // R2: hit coinciding with the advance pulse
        hit(4, 10, 1);
        exp_a.push_back(mkw(10, 4, xn, 1));
        exp_a.push_back(mkw(11, 4, xn, 2));
        hit_adv(4, 11, 2);
        advance();
        repeat (60) @(negedge rclk);
        check_stream("R2 same-edge");

        // R10: overflow and bad column
        d0 = drop_cnt;
        for (int h = 0; h < DEPTH + 1; h++) begin
            hit(9, 40 + h, h);
            if (h < DEPTH) exp_a.push_back(mkw(40 + h, 9, xn, h));
        end
        hit(NCOL, 5, 5);
        chk(drop_cnt == 16'(d0 + 2), "R10 drop count", drop_cnt, d0 + 2);
        advance();
        advance();
        repeat (60) @(negedge rclk);
        check_stream("R10 overflow");

        // R7 R9: late ready set behind the token forces a second sweep
        for (int c = 0; c < NCOL; c++)
            for (int h = 0; h < DEPTH; h++) begin
                hit(c, (c * 5 + h) & 127, h);
                exp_a.push_back(mkw((c * 5 + h) & 127, c, xn, h));
            end
        advance();
        hit(0, 100, 6); exp_b.push_back(mkw(100, 0, xn, 6));
        hit(0, 101, 7); exp_b.push_back(mkw(101, 0, xn, 7));
        hit(2, 102, 3); exp_b.push_back(mkw(102, 2, xn, 3));
        advance();
        repeat (30) @(negedge xclk);
        advance();
        repeat (300) @(negedge rclk);
        check_stream("R9 relaunch");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule